// File: doc/BRIEF.md
# External Interrupt Sense Controller

This peripheral watches eight external interrupt pins and turns activity on them into per-pin interrupt requests for a processor. Each pin is brought into the clock domain through a synchroniser and then compared against its previous sample. Software chooses, pin by pin, whether a low level, any change, a falling edge or a rising edge is the trigger.

Edge-type triggers latch into a per-pin event flag. Software clears a flag by writing a one to its bit, or the processor clears it in hardware with a one-cycle acknowledge pulse. Level-type triggers do not use the flag: the request follows the synchronised pin directly. A request leaves the block only when the pin's enable bit and the global interrupt enable input are both high.

Registers sit on a simple synchronous bus with a 2-bit address. The read data is combinational from the address.

| Address | Contents |
|---|---|
| 0 | Trigger fields for pins 3..0 |
| 1 | Trigger fields for pins 7..4 |
| 2 | Per-pin enable |
| 3 | Event flags (write one to clear) |

Top module: `ext_irq_sense`

## Requirements
- R1: After reset all four registers read as zero and `irq_req` is zero. The synchroniser and sample stages reset to one, so pins held high through reset produce no event.
- R2: Each pin has a 2-bit trigger field. Pin n with n below 4 uses bits [2n+1:2n] of address 0. Pin n with n of 4 or more uses bits [2(n-4)+1:2(n-4)] of address 1. Both registers read back what was written.
- R3: The trigger codes are 00 for low level, 01 for any change, 10 for falling edge and 11 for rising edge. Only a matching transition sets the flag, readable at address 3 bit n.
- R4: A pin change applied before clock edge k sets its flag after edge k+2, and not after edge k+1. This covers two synchroniser stages and one sample comparison.
- R5: A pulse lasting one clock period in any-change mode, or a one-period low pulse in falling mode, sets the flag.
- R6: In low-level mode the request is driven while the synchronised pin is low, with no flag involved. It ends two edges after the pin returns high, and address 3 stays zero.
- R7: Writing address 3 clears each flag whose data bit is one and leaves flags whose data bit is zero unchanged.
- R8: An event in the same cycle as a clearing write or acknowledge leaves the flag set.
- R9: A one-cycle pulse on `irq_ack[n]` clears only flag n.
- R10: `irq_req[n]` equals (flag n, or the low-level condition) AND enable bit n (address 2 bit n) AND `gie`.
- R11: Flags are set by events even while the pin's enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| gie | input | 1 | Global interrupt enable |
| pin_in | input | 8 | External interrupt pins, asynchronous |
| irq_ack | input | 8 | Per-pin flag clear from the processor |
| irq_req | output | 8 | Per-pin interrupt requests |

## Verification
The bench goes after the collision of an event with a clearing write. A design that gives the clear priority would lose that interrupt for good.

It measures the exact synchroniser latency. A stage too few or too many moves the flag by a cycle.

It also drives single-cycle pulses, which a design sampling too slowly would miss. It checks that level mode never latches a flag, and that a zero in the clear data, or an acknowledge on another pin, leaves neighbouring flags untouched.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    localparam int ADDR_W      = 2;
    localparam int A_SENSE_LO  = 0;
    localparam int A_SENSE_HI  = 1;
    localparam int A_ENABLE    = 2;
    localparam int A_FLAG      = 3;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] cur_o,
    output logic [NPINS-1:0] prev_o
);
    logic [NPINS-1:0] stg [SYNC_STAGES];

    // Synchroniser stage 0 takes the raw pins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= pin_i;
    end

    // Remaining synchroniser stages are chained.
    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '1;
                else        stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign cur_o = stg[SYNC_STAGES-1];

    // Previous sample, used by the edge comparison.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_o <= '1;
        else        prev_o <= cur_o;
    end

    // Checker: cycles since reset, saturating at 3.
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    generate
        if (SYNC_STAGES == 2) begin : g_chk
            // R4: the synchronised value is the pin two edges ago
            a_r4_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst == 2'd3) |-> (cur_o == $past(pin_i, 2)));
        end
    endgenerate
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
    import eirq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                  cur_i   [NPINS],
    input  logic                  prev_i  [NPINS],
    input  sense_e                sense_i [NPINS],
    output logic [NPINS-1:0]      evt_o,
    output logic [NPINS-1:0]      lvl_o
);
    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            always_comb begin
                evt_o[p] = 1'b0;
                lvl_o[p] = 1'b0;
                unique case (sense_i[p])
                    SNS_LOW:  lvl_o[p] = ~cur_i[p];
                    SNS_ANY:  evt_o[p] = cur_i[p] ^ prev_i[p];
                    SNS_FALL: evt_o[p] = prev_i[p] & ~cur_i[p];
                    SNS_RISE: evt_o[p] = ~prev_i[p] & cur_i[p];
                    default:  ;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPINS-1:0]  evt_i,
    input  logic [NPINS-1:0]  ack_i,
    output sense_e            sense_o [NPINS],
    output logic [NPINS-1:0]  enable_o,
    output logic [NPINS-1:0]  flag_o
);
    localparam int PER_REG = DW / 2;

    logic [DW-1:0]    sns_lo_q, sns_hi_q;
    logic [NPINS-1:0] en_q, flag_q, clr_w;

    wire wr_lo   = bus_we && (bus_addr == ADDR_W'(A_SENSE_LO));
    wire wr_hi   = bus_we && (bus_addr == ADDR_W'(A_SENSE_HI));
    wire wr_en   = bus_we && (bus_addr == ADDR_W'(A_ENABLE));
    wire wr_flag = bus_we && (bus_addr == ADDR_W'(A_FLAG));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sns_lo_q <= '0;
            sns_hi_q <= '0;
            en_q     <= '0;
        end else begin
            if (wr_lo) sns_lo_q <= bus_wdata;
            if (wr_hi) sns_hi_q <= bus_wdata;
            if (wr_en) en_q     <= bus_wdata[NPINS-1:0];
        end
    end

    // Clear sources: a write of ones to the flag register, or an acknowledge.
    // An event set takes priority over either clear.
    assign clr_w = (wr_flag ? bus_wdata[NPINS-1:0] : '0) | ack_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_w) | evt_i;
    end

    // Unpack the 2-bit trigger field of each pin.
    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_fld
            if (p < PER_REG) begin : g_lo
                assign sense_o[p] = sense_e'(sns_lo_q[2*p +: 2]);
            end else begin : g_hi
                assign sense_o[p] = sense_e'(sns_hi_q[2*(p-PER_REG) +: 2]);
            end
        end
    endgenerate

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(A_SENSE_LO): bus_rdata = sns_lo_q;
            ADDR_W'(A_SENSE_HI): bus_rdata = sns_hi_q;
            ADDR_W'(A_ENABLE):   bus_rdata = DW'(en_q);
            default:             bus_rdata = DW'(flag_q);
        endcase
    end

    assign enable_o = en_q;
    assign flag_o   = flag_q;

    // R8: an event always leaves its flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

    // R7: a written one clears its flag unless an event collides
    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flag |=> ((flag_q & $past(bus_wdata[NPINS-1:0] & ~evt_i)) == '0));

    // R9: an acknowledge clears its flag unless an event collides
    a_r9_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_i) |=> ((flag_q & $past(ack_i & ~evt_i)) == '0));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import eirq_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we,
    output logic [DW-1:0]     bus_rdata,
    input  logic              gie,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  irq_ack,
    output logic [NPINS-1:0]  irq_req
);
    logic [NPINS-1:0] cur_v, prev_v, evt, lvl, en, flag;
    logic             cur_a  [NPINS];
    logic             prev_a [NPINS];
    sense_e           sense  [NPINS];

    eirq_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .cur_o(cur_v), .prev_o(prev_v)
    );

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_unpack
            assign cur_a[p]  = cur_v[p];
            assign prev_a[p] = prev_v[p];
        end
    endgenerate

    eirq_detect #(.NPINS(NPINS)) u_det (
        .cur_i(cur_a), .prev_i(prev_a), .sense_i(sense), .evt_o(evt), .lvl_o(lvl)
    );

    eirq_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .evt_i(evt), .ack_i(irq_ack),
        .sense_o(sense), .enable_o(en), .flag_o(flag)
    );

    assign irq_req = (flag | lvl) & en & {NPINS{gie}};

    // R10: no request without the global enable
    a_r10_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |-> gie);

    // R6: an enabled low-level condition always reaches the output
    a_r6_level_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && |(lvl & en)) |-> |irq_req);
endmodule

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       gie = 1'b0;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] irq_ack = '0;
    logic [7:0] irq_req;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ext_irq_sense dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .gie(gie), .pin_in(pin_in),
        .irq_ack(irq_ack), .irq_req(irq_req)
    );

    // Table vector fields: {mode[1:0], start level, end level, expected flag}
    localparam logic [4:0] VEC [8] = '{
        {2'b00, 1'b1, 1'b0, 1'b0},
        {2'b00, 1'b0, 1'b1, 1'b0},
        {2'b01, 1'b1, 1'b0, 1'b1},
        {2'b01, 1'b0, 1'b1, 1'b1},
        {2'b10, 1'b1, 1'b0, 1'b1},
        {2'b10, 1'b0, 1'b1, 1'b0},
        {2'b11, 1'b0, 1'b1, 1'b1},
        {2'b11, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] v;

        step(3);
        rst_n = 1'b1;
        gie = 1'b1;
        step(1);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset reg", v, 8'h00);
        end
        step(4);
        rd(2'd3, v);
        check("R1 no event from idle pins", v, 8'h00);
        check("R1 irq_req idle", irq_req, 8'h00);

        // R3 R11: table of trigger modes on pin 0, enable clear
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, {6'b0, VEC[i][4:3]});
            pin_in[0] = VEC[i][2];
            step(4);
            wr(2'd3, 8'hFF);
            pin_in[0] = VEC[i][1];
            step(4);
            rd(2'd3, v);
            check("R3 R11 mode table flag", v, {7'b0, VEC[i][0]});
        end
        pin_in = 8'hFF;
        step(4);
        wr(2'd3, 8'hFF);

        // R2: field layout of the upper register, pin 7 rising, pin 4 low level
        wr(2'd1, 8'hC0);
        rd(2'd1, v);
        check("R2 readback upper", v, 8'hC0);
        pin_in[7] = 1'b0;
        step(4);
        wr(2'd3, 8'hFF);
        pin_in[7] = 1'b1;
        pin_in[4] = 1'b0;
        step(4);
        rd(2'd3, v);
        check("R2 pin7 field", v, 8'h80);
        pin_in = 8'hFF;
        step(4);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'hFF);

        // R4: latency, pin 1 rising (lower register bits 3:2 = 11)
        wr(2'd0, 8'h0C);
        pin_in[1] = 1'b0;
        step(4);
        wr(2'd3, 8'hFF);
        pin_in[1] = 1'b1;
        step(2);
        rd(2'd3, v);
        check("R4 not yet after k+1", v, 8'h00);
        step(1);
        rd(2'd3, v);
        check("R4 set after k+2", v, 8'h02);

        // R8: event collides with a clearing write
        wr(2'd3, 8'hFF);
        pin_in[1] = 1'b0;
        step(4);
        pin_in[1] = 1'b1;
        step(2);
        wr(2'd3, 8'h02);
        rd(2'd3, v);
        check("R8 set wins over clear", v, 8'h02);

        // R5: single-period pulses, pin 2 any change, pin 0 falling
        wr(2'd3, 8'hFF);
        wr(2'd0, 8'h12);
        step(4);
        wr(2'd3, 8'hFF);
        pin_in[2] = 1'b0;
        pin_in[0] = 1'b0;
        step(1);
        pin_in[2] = 1'b1;
        pin_in[0] = 1'b1;
        step(4);
        rd(2'd3, v);
        check("R5 one-period pulses", v, 8'h05);

        // R7: partial clear, and zero write has no effect
        wr(2'd3, 8'h00);
        rd(2'd3, v);
        check("R7 zero write keeps flags", v, 8'h05);
        wr(2'd3, 8'h04);
        rd(2'd3, v);
        check("R7 one clears only its bit", v, 8'h01);

        // R10: gating by enable and gie (flag 0 set)
        wr(2'd2, 8'h00);
        #1;
        check("R10 enable clear blocks", irq_req, 8'h00);
        wr(2'd2, 8'h01);
        gie = 1'b0;
        #1;
        check("R10 gie clear blocks", irq_req, 8'h00);
        gie = 1'b1;
        #1;
        check("R10 both set passes", irq_req, 8'h01);

        // R9: acknowledge clears only its own flag (flags 0 and 1 set)
        pin_in[1] = 1'b0;
        wr(2'd0, 8'h0C);
        step(4);
        pin_in[1] = 1'b1;
        step(4);
        rd(2'd3, v);
        check("R9 setup flags", v, 8'h03);
        irq_ack = 8'h01;
        step(1);
        irq_ack = 8'h00;
        rd(2'd3, v);
        check("R9 ack clears one flag", v, 8'h02);
        check("R9 request drops", irq_req, 8'h00);

        // R6: low-level mode on pin 3
        wr(2'd3, 8'hFF);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h08);
        pin_in[3] = 1'b0;
        step(1);
        check("R6 not yet after one edge", irq_req, 8'h00);
        step(1);
        check("R6 level request", irq_req, 8'h08);
        step(5);
        check("R6 held while low", irq_req, 8'h08);
        pin_in[3] = 1'b1;
        step(1);
        check("R6 still low one edge later", irq_req, 8'h08);
        step(1);
        check("R6 ends after release", irq_req, 8'h00);
        rd(2'd3, v);
        check("R6 no flag latched", v, 8'h00);

        summary();
    end
endmodule